// File: doc/BRIEF.md
# Four-Phase Handshake Link Port

This block carries parallel words over a link between two parties that share no clock. Each transfer is fully interlocked: every edge one side drives waits for the other side's answering edge. The local side offers a word through a valid/ready interface. The far side answers on one control input. A two-flop synchronizer cleans that input before the block uses it.

The block has two roles, chosen by `mode_i` when a word is accepted. In the source role it starts the transfer. It puts the word on the link, waits a set number of cycles, raises the strobe and holds both until the far side acknowledges. In the answering role it holds the accepted word until the far side raises a request. Only then does it drive the word and, after the same set delay, raise the strobe as a data-ready signal. A separate enable marks the cycles in which the data lines are driven, so an outside pad can float them otherwise.

Top module: `fourphase_link`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1 and `link_oe` and `link_strobe` are 0.
- R2: A word is taken only on a clock edge where `in_ready` and `in_valid` are both 1. `mode_i` is captured at that edge (0 = source role, 1 = answering role). A later change of `in_valid`, `in_data` or `mode_i` during a transfer does not change the link data or the role.
- R3: In the source role, `link_oe` rises on the edge that accepts the word and `link_strobe` rises exactly SETUP_CYC (default 4) cycles later, with `link_data_o` equal to the accepted word.
- R4: In the source role, `link_strobe` and `link_oe` stay high while `link_resp_i` (acknowledge) is low. Both fall together on the third rising edge after `link_resp_i` rises.
- R5: In the source role, `in_ready` stays 0 while the acknowledge stays high after the release. It returns to 1 on the third rising edge after `link_resp_i` falls.
- R6: In the answering role, `link_oe` and `link_strobe` stay 0 until `link_resp_i` (request) rises. `link_oe` rises on the third rising edge after that, and `link_strobe` rises SETUP_CYC cycles after `link_oe`, carrying the accepted word.
- R7: In the answering role, `link_strobe` and `link_oe` stay high while the request is high. Both fall, and `in_ready` rises, on the third rising edge after `link_resp_i` falls.
- R8: `link_strobe` is never 1 while `link_oe` is 0. `link_data_o` does not change while `link_oe` stays 1.
- R9: `in_ready` is 1 only while `link_oe` and `link_strobe` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Role chosen at acceptance: 0 source, 1 answering |
| in_valid | input | 1 | Local word offered |
| in_ready | output | 1 | Block idle and able to take a word |
| in_data | input | DATA_W | Local word |
| link_data_o | output | DATA_W | Word driven onto the link |
| link_oe | output | 1 | Link data lines are driven |
| link_strobe | output | 1 | Request (source role) or data ready (answering role) |
| link_resp_i | input | 1 | Far-side acknowledge (source role) or request (answering role), asynchronous |

## Verification
Both roles are run with several words: all-zero, all-one, alternating bit patterns and mixed values. Each word is paired with a different far-side hold time, so a link that releases on a timer instead of on the handshake edge shows up as a failure. The setup gap is counted cycle by cycle and the release is sampled on both sides of the three-edge synchronizer latency. That separates a correct synchronizer depth from one that is too short or too long. Local words and role changes injected mid-transfer tell a block that loads only when idle from one that reloads at any time. A reset during the setup phase checks that the link returns to its released state at once.

// File: rtl/fp_pkg.sv
package fp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_REQ = 3'd1,
        ST_SETUP    = 3'd2,
        ST_STROBE   = 3'd3,
        ST_WAIT_LOW = 3'd4
    } link_state_e;

    typedef enum logic {
        ROLE_SOURCE = 1'b0,
        ROLE_ANSWER = 1'b1
    } link_role_e;

    function automatic logic state_drives_data(link_state_e s);
        return (s == ST_SETUP) || (s == ST_STROBE);
    endfunction

endpackage

// File: rtl/fp_sync.sv
module fp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/fp_setup_timer.sv
module fp_setup_timer #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = $clog2(CYC) + 1;
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run_i) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done_o = run_i && (cnt == LAST);

    a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/fp_word_hold.sv
module fp_word_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)         q_o <= '0;
        else if (load_i) q_o <= d_i;
    end
endmodule

// File: rtl/fourphase_link.sv
module fourphase_link
    import fp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SETUP_CYC   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_i,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] link_data_o,
    output logic              link_oe,
    output logic              link_strobe,
    input  logic              link_resp_i
);
    link_state_e state, state_nx;
    link_role_e  role_q;
    logic        far_s;
    logic        setup_done;
    logic        take;

    fp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_i(link_resp_i), .sync_o(far_s)
    );

    fp_setup_timer #(.CYC(SETUP_CYC)) u_timer (
        .clk(clk), .rst(rst), .run_i(state == ST_SETUP), .done_o(setup_done)
    );

    assign take = (state == ST_IDLE) && in_valid;

    fp_word_hold #(.W(DATA_W)) u_hold (
        .clk(clk), .rst(rst), .load_i(take), .d_i(in_data), .q_o(link_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst)       role_q <= ROLE_SOURCE;
        else if (take) role_q <= link_role_e'(mode_i);
    end

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:     if (in_valid) state_nx = mode_i ? ST_WAIT_REQ : ST_SETUP;
            ST_WAIT_REQ: if (far_s) state_nx = ST_SETUP;
            ST_SETUP:    if (setup_done) state_nx = ST_STROBE;
            ST_STROBE: begin
                if (role_q == ROLE_SOURCE) begin
                    if (far_s) state_nx = ST_WAIT_LOW;
                end else if (!far_s) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_WAIT_LOW: if (!far_s) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign in_ready    = (state == ST_IDLE);
    assign link_oe     = state_drives_data(state);
    assign link_strobe = (state == ST_STROBE);

    a_r8_strobe_needs_data: assert property (@(posedge clk) disable iff (rst)
        link_strobe |-> link_oe);
    a_r8_data_stable: assert property (@(posedge clk) disable iff (rst)
        (link_oe && $past(link_oe)) |-> $stable(link_data_o));
    a_r3_setup_before_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(link_oe) |-> !link_strobe);
    a_r4_release_together: assert property (@(posedge clk) disable iff (rst)
        $fell(link_strobe) |-> !link_oe);
    a_r9_ready_when_released: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!link_oe && !link_strobe));
endmodule

// File: tb/fourphase_link_tb.sv
module fourphase_link_tb;
    localparam int W  = 8;
    localparam int SC = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_i = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic [W-1:0] link_data_o;
    logic         link_oe;
    logic         link_strobe;
    logic         link_resp_i = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    fourphase_link #(.DATA_W(W), .SETUP_CYC(SC), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .link_data_o(link_data_o),
        .link_oe(link_oe), .link_strobe(link_strobe), .link_resp_i(link_resp_i)
    );

    // {role, word, far-side hold cycles}
    localparam int NV = 6;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 8'hA5, 4'd1},
        {1'b0, 8'h00, 4'd3},
        {1'b1, 8'hFF, 4'd2},
        {1'b1, 8'h5A, 4'd5},
        {1'b0, 8'h3C, 4'd7},
        {1'b1, 8'hC3, 4'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic take_word(input logic m, input logic [W-1:0] d);
        chk("R9 ready before accept", {31'd0, in_ready}, 32'd1);
        mode_i   = m;
        in_valid = 1'b1;
        in_data  = d;
        step(1);
        in_valid = 1'b0;
        chk("R2 ready drops after accept", {31'd0, in_ready}, 32'd0);
    endtask

    task automatic count_setup(input string req, input logic [W-1:0] d);
        int n = 0;
        while (!link_strobe && n < 50) begin
            if (n == 1) begin in_valid = 1'b1; in_data = ~d; mode_i = ~mode_i; end
            if (n == 2) begin in_valid = 1'b0; end
            n++;
            step(1);
        end
        in_valid = 1'b0;
        chk(req, n, SC);
        chk("R2 word not reloaded mid-transfer", {24'd0, link_data_o}, {24'd0, d});
        chk("R8 data driven under strobe", {31'd0, link_oe}, 32'd1);
    endtask

    task automatic run_source(input logic [W-1:0] d, input int hold);
        take_word(1'b0, d);
        chk("R3 oe on accept edge", {31'd0, link_oe}, 32'd1);
        count_setup("R3 setup gap", d);
        step(hold);
        chk("R4 strobe held without ack", {31'd0, link_strobe}, 32'd1);
        link_resp_i = 1'b1;
        step(2);
        chk("R4 strobe not released early", {31'd0, link_strobe}, 32'd1);
        step(1);
        chk("R4 strobe released", {31'd0, link_strobe}, 32'd0);
        chk("R4 oe released", {31'd0, link_oe}, 32'd0);
        step(hold + 2);
        chk("R5 no ready while ack high", {31'd0, in_ready}, 32'd0);
        link_resp_i = 1'b0;
        step(2);
        chk("R5 ready not early", {31'd0, in_ready}, 32'd0);
        step(1);
        chk("R5 ready after ack low", {31'd0, in_ready}, 32'd1);
        mode_i = 1'b0;
    endtask

    task automatic run_answer(input logic [W-1:0] d, input int hold);
        take_word(1'b1, d);
        mode_i = 1'b0;
        step(hold + 3);
        chk("R6 oe idle before request", {31'd0, link_oe}, 32'd0);
        chk("R6 strobe idle before request", {31'd0, link_strobe}, 32'd0);
        chk("R2 role kept after mode change", {31'd0, in_ready}, 32'd0);
        link_resp_i = 1'b1;
        step(2);
        chk("R6 oe not early", {31'd0, link_oe}, 32'd0);
        step(1);
        chk("R6 oe after request", {31'd0, link_oe}, 32'd1);
        count_setup("R6 setup gap", d);
        step(hold);
        chk("R7 strobe held with request", {31'd0, link_strobe}, 32'd1);
        link_resp_i = 1'b0;
        step(2);
        chk("R7 strobe not released early", {31'd0, link_strobe}, 32'd1);
        step(1);
        chk("R7 strobe released", {31'd0, link_strobe}, 32'd0);
        chk("R7 oe released", {31'd0, link_oe}, 32'd0);
        chk("R7 ready returns", {31'd0, in_ready}, 32'd1);
        mode_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1 ready after reset", {31'd0, in_ready}, 32'd1);
        chk("R1 oe after reset", {31'd0, link_oe}, 32'd0);
        chk("R1 strobe after reset", {31'd0, link_strobe}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][12]) run_answer(VEC[i][11:4], int'(VEC[i][3:0]));
            else            run_source(VEC[i][11:4], int'(VEC[i][3:0]));
            step(2);
        end

        // back-to-back source transfers with ack returned immediately
        run_source(8'h81, 0);
        run_source(8'h7E, 0);

        // reset during setup releases the link at once
        take_word(1'b0, 8'h99);
        step(1);
        rst = 1'b1;
        step(1);
        chk("R1 oe cleared by reset", {31'd0, link_oe}, 32'd0);
        chk("R1 ready set by reset", {31'd0, in_ready}, 32'd1);
        rst = 1'b0;
        step(2);

        // idle with no valid: link stays released
        step(5);
        chk("R9 idle link released", {30'd0, link_oe, link_strobe}, 32'd0);
        chk("R9 idle ready", {31'd0, in_ready}, 32'd1);

        finish_run();
    end
endmodule